// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Interface

This block connects a processing core to a 16-bit memory built from two 8-bit banks. The low bank holds even byte addresses on data bits 7..0. The high bank holds odd byte addresses on data bits 15..8. The core issues byte or 16-bit word reads and writes at any byte address. The block turns each request into one or two bank cycles and moves every byte onto the correct half of the bus.

A word at an even address needs a single cycle that enables both banks. A word at an odd address cannot be served that way, because its two bytes sit in different rows. The block splits it into two single-bank cycles: first the high bank of the current row, then the low bank of the next row. The two bytes are swapped on the way out for a write and reassembled on the way back for a read.

The core holds its request until `req_ready` is high. Read results come back one cycle later with a single-cycle `rsp_valid` pulse.

Top module: `lane_split_mem`

## Requirements
- R1: A byte access drives `mem_addr` = byte address >> 1 and enables exactly one bank, chosen by address bit 0: 0 selects the low bank (`mem_en` = 2'b01, bits 7..0) and 1 selects the high bank (`mem_en` = 2'b10, bits 15..8).
- R2: A byte write places the write byte (`req_wdata[7:0]`) on the enabled bank's lane. A byte read returns that bank's byte in `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` zero.
- R3: A word access at an even address completes in one bank cycle with `mem_en` = 2'b11, little-endian: `req_wdata[7:0]` / `rsp_rdata[7:0]` is the byte at the given address (low bank) and bits 15..8 are the byte at the next address (high bank).
- R4: A word access at an odd address takes two bank cycles. The first uses `mem_en` = 2'b10 at row address >> 1. The second uses `mem_en` = 2'b01 at that row plus one, wrapping at the top of the row range.
- R5: For an odd-address word, a write drives `req_wdata[7:0]` on bits 15..8 in the first cycle and `req_wdata[15:8]` on bits 7..0 in the second. A read returns {second-cycle bits 7..0, first-cycle bits 15..8}.
- R6: `req_ready` is high only in the cycle in which the last bank cycle of the request completes (bank enabled and `mem_ready` high). The core holds its request unchanged until then.
- R7: After a read completes, `rsp_valid` is high for exactly one cycle, on the next cycle, with the result on `rsp_rdata`. Writes produce no `rsp_valid`.
- R8: `mem_we` is high only in cycles with at least one bank enabled. No bank is enabled while `req_valid` is low.
- R9: A cycle with `mem_ready` low makes no progress: `req_ready` stays low, and the next cycle repeats the same bank address and enables.
- R10: After reset the block is idle: it starts at the first bank cycle of a request, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Request finished in this cycle |
| req_addr | input | ADDR_W | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte in bits 7..0) |
| rsp_valid | output | 1 | Read result pulse |
| rsp_rdata | output | 16 | Read result |
| mem_addr | output | ADDR_W-1 | Bank row address |
| mem_en | output | 2 | Bank enables, bit 0 low bank, bit 1 high bank |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | 16 | Data to the banks |
| mem_rdata | input | 16 | Data from the banks |
| mem_ready | input | 1 | Bank cycle completes at this edge |

## Verification
The checker watches every cycle for the lane and bank rules:
- a single bank chosen by address bit 0 for bytes;
- both banks for even words;
- a write strobe only with an enable;
- a completion only on a `mem_ready` cycle;
- the high-then-low order with the incremented row for odd words;
- bus stability during stalls;
- a response pulse after each completed read.

Only the bench scenarios show that the right bytes arrive. Its bank model and byte-array reference check the byte swap of odd words, the zero-extension of byte reads, the row wrap at the top address, and the little-endian layout left in the banks after a long mixed run.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
    localparam int LANE_W = 8;
    localparam int BUS_W  = 2 * LANE_W;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e              phase;
        logic [LANE_W-1:0]   held_lo;
        logic                rsp_valid;
        logic [BUS_W-1:0]    rsp_data;
    } ctl_s;
endpackage

// File: rtl/lsm_bank_sel.sv
module lsm_bank_sel
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int ROW_W = ADDR_W - 1
) (
    input  logic              active,
    input  logic [ADDR_W-1:0] byte_addr,
    input  logic              is_word,
    input  phase_e            phase,
    output logic [ROW_W-1:0]  row,
    output logic [1:0]        bank_en,
    output logic              last
);
    logic              odd;
    logic [ROW_W-1:0]  base_row;

    assign odd      = byte_addr[0];
    assign base_row = byte_addr[ADDR_W-1:1];

    always_comb begin
        row     = base_row;
        bank_en = 2'b00;
        last    = 1'b1;
        if (is_word && odd) begin
            last = (phase == PH_SECOND);
            if (phase == PH_SECOND) begin
                row     = base_row + 1'b1;
                bank_en = 2'b01;
            end else begin
                bank_en = 2'b10;
            end
        end else if (is_word) begin
            bank_en = 2'b11;
        end else begin
            bank_en = odd ? 2'b10 : 2'b01;
        end
        if (!active) begin
            bank_en = 2'b00;
        end
    end
endmodule

// File: rtl/lsm_lane_steer.sv
module lsm_lane_steer
    import lsm_pkg::*;
(
    input  logic              odd,
    input  logic              is_word,
    input  logic [BUS_W-1:0]  core_wdata,
    input  logic [BUS_W-1:0]  bus_rdata,
    input  logic [LANE_W-1:0] held_lo,
    output logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  result,
    output logic [LANE_W-1:0] first_byte
);
    logic [LANE_W-1:0] lane_rd [2];

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign lane_rd[g] = bus_rdata[g*LANE_W +: LANE_W];
    end

    assign first_byte = lane_rd[1];

    always_comb begin
        if (!is_word) begin
            bus_wdata = {core_wdata[LANE_W-1:0], core_wdata[LANE_W-1:0]};
            result    = {{LANE_W{1'b0}}, odd ? lane_rd[1] : lane_rd[0]};
        end else if (odd) begin
            bus_wdata = {core_wdata[LANE_W-1:0], core_wdata[BUS_W-1:LANE_W]};
            result    = {lane_rd[0], held_lo};
        end else begin
            bus_wdata = core_wdata;
            result    = bus_rdata;
        end
    end
endmodule

// File: rtl/lane_split_mem.sv
module lane_split_mem
    import lsm_pkg::*;
#(
    parameter int ADDR_W = 16,
    localparam int ROW_W = ADDR_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ROW_W-1:0]  mem_addr,
    output logic [1:0]        mem_en,
    output logic              mem_we,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    input  logic              mem_ready
);
    ctl_s st_q, st_d;

    logic              last;
    logic              done;
    logic [BUS_W-1:0]  result;
    logic [LANE_W-1:0] first_byte;

    lsm_bank_sel #(.ADDR_W(ADDR_W)) bank_sel_i (
        .active    (req_valid),
        .byte_addr (req_addr),
        .is_word   (req_word),
        .phase     (st_q.phase),
        .row       (mem_addr),
        .bank_en   (mem_en),
        .last      (last)
    );

    lsm_lane_steer lane_steer_i (
        .odd        (req_addr[0]),
        .is_word    (req_word),
        .core_wdata (req_wdata),
        .bus_rdata  (mem_rdata),
        .held_lo    (st_q.held_lo),
        .bus_wdata  (mem_wdata),
        .result     (result),
        .first_byte (first_byte)
    );

    assign done      = req_valid && mem_ready;
    assign req_ready = done && last;
    assign mem_we    = req_write && (mem_en != 2'b00);
    assign rsp_valid = st_q.rsp_valid;
    assign rsp_rdata = st_q.rsp_data;

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = 1'b0;
        if (done) begin
            if (!last) begin
                st_d.phase   = PH_SECOND;
                st_d.held_lo = first_byte;
            end else begin
                st_d.phase = PH_FIRST;
                if (!req_write) begin
                    st_d.rsp_valid = 1'b1;
                    st_d.rsp_data  = result;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/lane_split_mem_chk.sv
module lane_split_mem_chk #(
    parameter int ADDR_W = 16,
    localparam int ROW_W = ADDR_W - 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_word,
    input logic              req_write,
    input logic              rsp_valid,
    input logic [ROW_W-1:0]  mem_addr,
    input logic [1:0]        mem_en,
    input logic              mem_we,
    input logic              mem_ready
);
    // R1
    byte_one_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_word) |-> ($countones(mem_en) == 1 && mem_en[1] == req_addr[0]
                                      && mem_addr == req_addr[ADDR_W-1:1]));

    // R3
    even_word_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && !req_addr[0]) |-> (mem_en == 2'b11 && !(mem_ready && !req_ready)));

    // R4
    odd_word_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && req_addr[0] && mem_en == 2'b10 && mem_ready)
        |=> (mem_en == 2'b01 && mem_addr == $past(mem_addr) + 1'b1));

    // R6
    odd_word_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word && req_addr[0] && mem_en == 2'b10) |-> !req_ready);

    // R6
    ready_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (req_valid && mem_ready && mem_en != 2'b00));

    // R7
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rsp_valid);

    // R7
    write_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready && !req_write) |=> !rsp_valid);

    // R8
    strobe_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_en != 2'b00));

    // R8
    idle_no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (mem_en == 2'b00));

    // R9
    stall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_en)));
endmodule

bind lane_split_mem lane_split_mem_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_word  (req_word),
    .req_write (req_write),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_ready (mem_ready)
);

// File: tb/lane_split_mem_tb_top.sv
`timescale 1ns/1ps
module lane_split_mem_tb_top;
    localparam int AW   = 8;
    localparam int RW   = AW - 1;
    localparam int NROW = 1 << RW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid, req_ready, req_word, req_write;
    logic [AW-1:0] req_addr;
    logic [15:0]   req_wdata, rsp_rdata, mem_wdata, mem_rdata;
    logic          rsp_valid, mem_we, mem_ready;
    logic [RW-1:0] mem_addr;
    logic [1:0]    mem_en;

    logic [7:0] bank_lo [NROW];
    logic [7:0] bank_hi [NROW];
    logic [7:0] ref_mem [2*NROW];

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    lane_split_mem #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_word(req_word), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NROW; i++) begin
                bank_lo[i] <= 8'(i * 7 + 3);
                bank_hi[i] <= 8'(i * 13 + 5);
            end
        end else if (mem_we && mem_ready) begin
            if (mem_en[0]) bank_lo[mem_addr] <= mem_wdata[7:0];
            if (mem_en[1]) bank_hi[mem_addr] <= mem_wdata[15:8];
        end
    end
    assign mem_rdata = {bank_hi[mem_addr], bank_lo[mem_addr]};

    function automatic logic [1:0] exp_en(input bit w, input bit odd, input int idx);
        if (idx == 1) return 2'b01;
        if (!w) return odd ? 2'b10 : 2'b01;
        return odd ? 2'b10 : 2'b11;
    endfunction

    function automatic logic [15:0] exp_read(input logic [AW-1:0] a, input bit w);
        if (!w) return {8'h00, ref_mem[a]};
        return {ref_mem[a + 8'd1], ref_mem[a]};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [AW-1:0] a, input bit w, input bit wr,
                        input logic [15:0] wd, input int stall_pct);
        logic [1:0]    en_s [2];
        logic [RW-1:0] ad_s [2];
        logic [15:0]   wd_s [2];
        logic          we_s [2];
        int            nb = 0;
        bit            fin = 0;
        bit            odd = a[0];
        logic [RW-1:0] row = a[AW-1:1];
        int            exp_nb = (w && odd) ? 2 : 1;
        logic [15:0]   er;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = wd;
        while (!fin) begin
            mem_ready = ($urandom_range(99) >= stall_pct);
            #1;
            if (!mem_ready) check(!req_ready, "R9 stall keeps ready low", 32'(req_ready), 0);
            if (mem_en != 2'b00 && mem_ready) begin
                if (nb < 2) begin
                    en_s[nb] = mem_en; ad_s[nb] = mem_addr; wd_s[nb] = mem_wdata; we_s[nb] = mem_we;
                end
                nb++;
            end
            if (req_ready) fin = 1;
            @(negedge clk);
        end
        req_valid = 1'b0; mem_ready = 1'b0;
        #1;
        check(nb == exp_nb, "R6 bank cycles before ready", 32'(nb), 32'(exp_nb));
        for (int i = 0; i < exp_nb && i < nb; i++) begin
            check(en_s[i] == exp_en(w, odd, i), (w && odd) ? "R4 odd word enables" : "R1 R3 enables",
                  32'(en_s[i]), 32'(exp_en(w, odd, i)));
            check(ad_s[i] == row + RW'(i), "R1 R4 row address", 32'(ad_s[i]), 32'(row + RW'(i)));
            check(we_s[i] == wr, "R8 write strobe", 32'(we_s[i]), 32'(wr));
        end
        if (wr && nb == exp_nb) begin
            if (!w)
                check((odd ? wd_s[0][15:8] : wd_s[0][7:0]) == wd[7:0], "R2 byte write lane",
                      32'(odd ? wd_s[0][15:8] : wd_s[0][7:0]), 32'(wd[7:0]));
            else if (!odd)
                check(wd_s[0] == wd, "R3 even word write", 32'(wd_s[0]), 32'(wd));
            else
                check({wd_s[1][7:0], wd_s[0][15:8]} == wd, "R5 odd word write swap",
                      32'({wd_s[1][7:0], wd_s[0][15:8]}), 32'(wd));
        end
        check(rsp_valid == !wr, "R7 response pulse present", 32'(rsp_valid), 32'(!wr));
        check(mem_en == 2'b00, "R8 no enable when idle", 32'(mem_en), 0);
        if (!wr) begin
            er = exp_read(a, w);
            check(rsp_rdata == er, !w ? "R2 byte read" : (odd ? "R5 odd word read" : "R3 even word read"),
                  32'(rsp_rdata), 32'(er));
        end else begin
            ref_mem[a] = wd[7:0];
            if (w) ref_mem[a + 8'd1] = wd[15:8];
        end
        @(negedge clk);
        #1;
        check(!rsp_valid, "R7 response lasts one cycle", 32'(rsp_valid), 0);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(100000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int bad;
        void'($urandom(32'd1234));
        for (int i = 0; i < NROW; i++) begin
            ref_mem[2*i]   = 8'(i * 7 + 3);
            ref_mem[2*i+1] = 8'(i * 13 + 5);
        end
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_word = 1'b0;
        req_write = 1'b0; req_wdata = '0; mem_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!rsp_valid && !req_ready && mem_en == 2'b00, "R10 reset idle",
              32'({rsp_valid, req_ready, mem_en}), 0);

        // directed corners
        xfer(8'h10, 1'b0, 1'b0, 16'h0, 0);     // even byte read
        xfer(8'h11, 1'b0, 1'b0, 16'h0, 0);     // odd byte read
        xfer(8'h21, 1'b0, 1'b1, 16'hBEA5, 0);  // odd byte write
        xfer(8'h21, 1'b1, 1'b0, 16'h0, 0);     // odd word read over it
        xfer(8'h40, 1'b1, 1'b1, 16'h1234, 0);  // even word write
        xfer(8'h40, 1'b1, 1'b0, 16'h0, 0);
        xfer(8'h41, 1'b1, 1'b1, 16'hCAFE, 0);  // odd word write
        xfer(8'h41, 1'b1, 1'b0, 16'h0, 60);    // odd word read with stalls
        xfer(8'hFF, 1'b1, 1'b1, 16'h9A7C, 0);  // row wrap
        xfer(8'hFF, 1'b1, 1'b0, 16'h0, 0);
        xfer(8'h00, 1'b1, 1'b0, 16'h0, 40);

        for (int n = 0; n < 300; n++) begin
            xfer(8'($urandom_range(255)), 1'($urandom_range(1)), 1'($urandom_range(1)),
                 16'($urandom), 30);
        end

        bad = 0;
        for (int i = 0; i < NROW; i++) begin
            if (bank_lo[i] != ref_mem[2*i] || bank_hi[i] != ref_mem[2*i+1]) bad++;
        end
        check(bad == 0, "R3 little-endian bank contents", 32'(bad), 0);
        finish_run();
    end
endmodule